// File: doc/BRIEF.md
# Packet Transfer Sequencer with Pause Hold

This block drives a byte-serial engine on behalf of software. A transfer is a run of equal packets: the packet size and the packet count are taken from two configuration fields, each holding its value minus one. The block unpacks 32-bit words from a transmit FIFO into bytes, hands one byte per handshake to the serial engine, and collects the byte that comes back into 32-bit words for a receive FIFO. Bytes fill each word from the least significant byte upwards.

A start command launches a transfer from idle. When the last byte is exchanged, the block either returns to idle and drops chip select, or, with pause mode on, keeps chip select asserted and waits in a paused state until a resume command launches the next transfer. Completion and pause events set sticky flags. A status read clears the flags, and two enables gate the flags onto one interrupt line. A level software reset, raised and then lowered, returns the block to idle and empties both FIFOs.

Word and byte interfaces are valid/ready. A transfer happens on a clock edge where valid and ready are both high. Valid does not wait for ready. The block stalls the serial side whenever the transmit FIFO is empty or the receive FIFO is full, so either FIFO can push back on the byte stream without loss.

Top module: `pkt_seq`

## Requirements
- R1: A transfer exchanges exactly (pkt_len_m1+1)*(pkt_loop_m1+1) bytes. pkt_len_m1 is 10 bits wide and pkt_loop_m1 is 8 bits wide. Both are captured when a transfer launches, so later changes do not affect a running transfer.
- R2: go launches a transfer only from idle. A go seen while busy or paused has no effect.
- R3: resume launches a transfer only from paused. A resume seen while idle or busy has no effect.
- R4: When the last byte is exchanged, a set pause_en moves the block to paused, keeps cs_active high and sets the pause flag. A clear pause_en returns the block to idle, lowers cs_active and sets the finish flag. cs_active is high exactly when the block is not idle.
- R5: While soft_rst is high, the block enters idle on the next edge and clears both flags and both FIFOs. During soft_rst, tx_wready, rx_rvalid and ser_valid are low.
- R6: Transmit bytes are taken from the head word starting at bits [7:0] and moving upwards. The word is popped after its fourth byte, or after the transfer's last byte. In the second case its unused upper bytes are discarded.
- R7: Received bytes fill a word starting at bits [7:0]. The word is pushed after four bytes, or after the transfer's last byte. In the second case the unfilled upper bytes are zero.
- R8: irq = (finish flag AND finish_ie) OR (pause flag AND pause_ie).
- R9: A stat_rd pulse clears both flags at the next edge. A flag set by an event on that same edge stays set.
- R10: ser_valid is high only while busy, the transmit FIFO is not empty and the receive FIFO is not full. The byte position advances only on a ser_valid/ser_ready handshake.
- R11: Each FIFO holds 8 words (32 bytes). tx_wready is low when the transmit FIFO is full, and rx_rvalid is high when the receive FIFO is not empty. status[0] is the finish flag, status[1] is the pause flag, and status[3:2] is the state: 0 idle, 1 busy, 2 paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Level software reset |
| pkt_len_m1 | input | 10 | Bytes per packet minus one |
| pkt_loop_m1 | input | 8 | Packets per transfer minus one |
| pause_en | input | 1 | Hold chip select and pause at completion |
| finish_ie | input | 1 | Finish interrupt enable |
| pause_ie | input | 1 | Pause interrupt enable |
| go | input | 1 | Start pulse (from idle) |
| resume | input | 1 | Resume pulse (from paused) |
| stat_rd | input | 1 | Status read strobe, clears flags |
| status | output | 4 | {state, pause flag, finish flag} |
| irq | output | 1 | Interrupt request |
| cs_active | output | 1 | Chip select asserted |
| tx_wvalid | input | 1 | Transmit word valid |
| tx_wready | output | 1 | Transmit FIFO can accept |
| tx_wdata | input | 32 | Transmit word |
| rx_rvalid | output | 1 | Receive word available |
| rx_rready | input | 1 | Receive word consumed |
| rx_rdata | output | 32 | Receive word |
| ser_valid | output | 1 | Byte ready for serial engine |
| ser_ready | input | 1 | Serial engine exchanges a byte |
| ser_txd | output | 8 | Byte to send |
| ser_rxd | input | 8 | Byte received, sampled at handshake |

## Verification
The embedded properties check on every cycle the state transitions of the sequencer. They cover the launch from idle, holding in paused until resume, and the choice between paused and idle at the last byte. They also check that handshakes happen only while busy, that soft reset flushes both FIFOs, and that neither FIFO overflows or underflows. The packet count arithmetic, the byte order inside words, the zero fill of a partial last word, the stall when the receive FIFO fills, and the capture of configuration at launch are shown only by the bench scenarios. In those scenarios a queue-based reference model predicts every output each cycle.

// File: rtl/pkt_seq_pkg.sv
package pkt_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_BUSY   = 2'd1,
    SQ_PAUSED = 2'd2
  } sq_state_t;
endpackage

// File: rtl/word_fifo.sv
module word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign dout  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else if (flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R11
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/pkt_seq_ctrl.sv
module pkt_seq_ctrl
  import pkt_seq_pkg::*;
#(
  parameter int LEN_W  = 10,
  parameter int LOOP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [LOOP_W-1:0] loop_m1,
  input  logic              pause_en,
  input  logic              go,
  input  logic              resume,
  input  logic              stat_rd,
  input  logic              hs,
  output sq_state_t         state,
  output logic              last_byte,
  output logic              fin_flag,
  output logic              pau_flag
);
  logic [LEN_W-1:0]  len_q, byte_cnt;
  logic [LOOP_W-1:0] loop_q, pkt_cnt;
  logic              launch;

  assign launch    = ((state == SQ_IDLE) && go) || ((state == SQ_PAUSED) && resume);
  assign last_byte = (state == SQ_BUSY) && (byte_cnt == len_q) && (pkt_cnt == loop_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE; len_q <= '0; loop_q <= '0;
      byte_cnt <= '0; pkt_cnt <= '0; fin_flag <= 1'b0; pau_flag <= 1'b0;
    end else if (soft_rst) begin
      state <= SQ_IDLE; len_q <= '0; loop_q <= '0;
      byte_cnt <= '0; pkt_cnt <= '0; fin_flag <= 1'b0; pau_flag <= 1'b0;
    end else begin
      if (stat_rd) begin
        fin_flag <= 1'b0;
        pau_flag <= 1'b0;
      end
      if (launch) begin
        state    <= SQ_BUSY;
        len_q    <= len_m1;
        loop_q   <= loop_m1;
        byte_cnt <= '0;
        pkt_cnt  <= '0;
      end else if ((state == SQ_BUSY) && hs) begin
        if (last_byte) begin
          byte_cnt <= '0;
          pkt_cnt  <= '0;
          if (pause_en) begin
            state    <= SQ_PAUSED;
            pau_flag <= 1'b1;
          end else begin
            state    <= SQ_IDLE;
            fin_flag <= 1'b1;
          end
        end else if (byte_cnt == len_q) begin
          byte_cnt <= '0;
          pkt_cnt  <= pkt_cnt + 1'b1;
        end else begin
          byte_cnt <= byte_cnt + 1'b1;
        end
      end
    end
  end

  // R2
  go_launch_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (state == SQ_IDLE) && go |=> state == SQ_BUSY);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (state == SQ_IDLE) && !go |=> state == SQ_IDLE);
  // R3
  paused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (state == SQ_PAUSED) && !resume |=> state == SQ_PAUSED);
  // R4
  pause_entry_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    hs && last_byte && pause_en |=> (state == SQ_PAUSED) && pau_flag);
  // R4
  finish_entry_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    hs && last_byte && !pause_en |=> (state == SQ_IDLE) && fin_flag);
  // R10
  hs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs |-> state == SQ_BUSY);
endmodule

// File: rtl/pkt_seq.sv
module pkt_seq
  import pkt_seq_pkg::*;
#(
  parameter int LEN_W      = 10,
  parameter int LOOP_W     = 8,
  parameter int FIFO_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [LEN_W-1:0]  pkt_len_m1,
  input  logic [LOOP_W-1:0] pkt_loop_m1,
  input  logic              pause_en,
  input  logic              finish_ie,
  input  logic              pause_ie,
  input  logic              go,
  input  logic              resume,
  input  logic              stat_rd,
  output logic [3:0]        status,
  output logic              irq,
  output logic              cs_active,
  input  logic              tx_wvalid,
  output logic              tx_wready,
  input  logic [31:0]       tx_wdata,
  output logic              rx_rvalid,
  input  logic              rx_rready,
  output logic [31:0]       rx_rdata,
  output logic              ser_valid,
  input  logic              ser_ready,
  output logic [7:0]        ser_txd,
  input  logic [7:0]        ser_rxd
);
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int DEPTH      = FIFO_BYTES / WORD_BYTES;
  localparam int LANE_W     = $clog2(WORD_BYTES);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(WORD_BYTES - 1);

  sq_state_t          state;
  logic               last_byte, fin_flag, pau_flag, hs, word_end;
  logic               tx_empty, tx_full, rx_empty, rx_full;
  logic [WORD_W-1:0]  tx_head, rx_acc, rx_word;
  logic [LANE_W-1:0]  lane;

  pkt_seq_ctrl #(.LEN_W(LEN_W), .LOOP_W(LOOP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .len_m1(pkt_len_m1), .loop_m1(pkt_loop_m1), .pause_en(pause_en),
    .go(go), .resume(resume), .stat_rd(stat_rd), .hs(hs),
    .state(state), .last_byte(last_byte), .fin_flag(fin_flag), .pau_flag(pau_flag)
  );

  assign tx_wready = !tx_full && !soft_rst;
  assign rx_rvalid = !rx_empty && !soft_rst;

  word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .push(tx_wvalid && tx_wready), .din(tx_wdata),
    .pop(hs && word_end), .dout(tx_head), .empty(tx_empty), .full(tx_full)
  );

  word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .push(hs && word_end), .din(rx_word),
    .pop(rx_rvalid && rx_rready), .dout(rx_rdata), .empty(rx_empty), .full(rx_full)
  );

  assign ser_valid = !soft_rst && (state == SQ_BUSY) && !tx_empty && !rx_full;
  assign hs        = ser_valid && ser_ready;
  assign word_end  = last_byte || (lane == LAST_LANE);
  assign ser_txd   = tx_head[{lane, 3'b000} +: 8];
  assign rx_word   = rx_acc | (WORD_W'(ser_rxd) << {lane, 3'b000});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane   <= '0;
      rx_acc <= '0;
    end else if (soft_rst) begin
      lane   <= '0;
      rx_acc <= '0;
    end else if (hs) begin
      lane   <= word_end ? '0 : lane + 1'b1;
      rx_acc <= word_end ? '0 : rx_word;
    end
  end

  assign status    = {state, pau_flag, fin_flag};
  assign cs_active = (state != SQ_IDLE);
  assign irq       = (fin_flag && finish_ie) || (pau_flag && pause_ie);

  // R5
  soft_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (state == SQ_IDLE) && tx_empty && rx_empty && !fin_flag && !pau_flag);
  // R6
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    !hs |=> $stable(lane));
endmodule

// File: tb/tb_pkt_seq.sv
`timescale 1ns/1ps
module tb_pkt_seq;
  logic clk = 0, rst_n = 0, soft_rst = 0;
  logic [9:0] pkt_len_m1 = 0;
  logic [7:0] pkt_loop_m1 = 0;
  logic pause_en = 0, finish_ie = 0, pause_ie = 0, go = 0, resume = 0, stat_rd = 0;
  logic [3:0] status;
  logic irq, cs_active, tx_wvalid = 0, tx_wready, rx_rvalid, rx_rready = 0;
  logic [31:0] tx_wdata = 0, rx_rdata;
  logic ser_valid, ser_ready = 1;
  logic [7:0] ser_txd, ser_rxd;

  assign ser_rxd = ser_txd ^ 8'h5A;

  pkt_seq dut (.*);

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0, cyc = 0, hs_cnt = 0, seq = 0;
  bit tx_acc = 0, feed_en = 0, rx_drain = 0, ser_toggle = 0, done = 0;

  // reference model
  int mstate = 0, total = 0, cnt = 0, ml = 0;
  bit mfin = 0, mpau = 0;
  logic [31:0] txq[$], rxq[$], macc = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    logic e_wready, e_rvalid, e_sval, hs, last;
    logic [7:0] tb, rb;
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
    if (!rst_n) begin
      mstate = 0; mfin = 0; mpau = 0; txq.delete(); rxq.delete();
      ml = 0; macc = 0; cnt = 0; tx_acc = 0;
    end else begin
      e_wready = !soft_rst && txq.size() < 8;
      e_rvalid = !soft_rst && rxq.size() > 0;
      e_sval   = !soft_rst && mstate == 1 && txq.size() > 0 && rxq.size() < 8;
      chk("R11 status", status, {28'd0, 2'(mstate), mpau, mfin});
      chk("R4 cs_active", cs_active, mstate != 0);
      chk("R8 irq", irq, (mfin && finish_ie) || (mpau && pause_ie));
      chk("R11 tx_wready", tx_wready, e_wready);
      chk("R11 rx_rvalid", rx_rvalid, e_rvalid);
      chk("R10 ser_valid", ser_valid, e_sval);
      if (e_sval) chk("R6 ser_txd", ser_txd, txq[0][8*ml +: 8]);
      if (e_rvalid) chk("R7 rx_rdata", rx_rdata, rxq[0]);
      tx_acc = tx_wvalid && e_wready;
      hs = e_sval && ser_ready;
      if (hs) hs_cnt++;
      // advance model to the state after the coming edge
      if (soft_rst) begin
        mstate = 0; mfin = 0; mpau = 0; txq.delete(); rxq.delete(); ml = 0; macc = 0; cnt = 0;
      end else begin
        if (e_rvalid && rx_rready) void'(rxq.pop_front());
        if (tx_acc) txq.push_back(tx_wdata);
        if (stat_rd) begin mfin = 0; mpau = 0; end
        case (mstate)
          0: if (go) begin mstate = 1; total = (pkt_len_m1 + 1) * (pkt_loop_m1 + 1); cnt = 0; end
          1: if (hs) begin
               tb = txq[0][8*ml +: 8];
               rb = tb ^ 8'h5A;
               cnt++;
               last = (cnt == total);
               macc[8*ml +: 8] = rb;
               if (last || ml == 3) begin
                 rxq.push_back(macc); macc = 0;
                 void'(txq.pop_front()); ml = 0;
               end else ml++;
               if (last) begin
                 if (pause_en) begin mstate = 2; mpau = 1; end
                 else begin mstate = 0; mfin = 1; end
               end
             end
          default: if (resume) begin mstate = 1; total = (pkt_len_m1 + 1) * (pkt_loop_m1 + 1); cnt = 0; end
        endcase
      end
    end
  end

  initial forever begin
    @(posedge clk); #1;
    if (tx_acc) seq++;
    tx_wdata  = {8'(4*seq+3), 8'(4*seq+2), 8'(4*seq+1), 8'(4*seq)};
    tx_wvalid = feed_en;
    rx_rready = rx_drain;
    ser_ready = ser_toggle ? ~ser_ready : 1'b1;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(ref logic s);
    s = 1; step(1); s = 0;
  endtask

  task automatic wait_state(input logic [1:0] want);
    for (int k = 0; k < 3000 && status[3:2] != want; k++) step(1);
    step(1);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    chk("R11 reset status", status, 4'h0);
    chk("R4 reset cs", cs_active, 1'b0);
    feed_en = 1; rx_drain = 1; finish_ie = 1; pause_ie = 1;
    step(12);
    // 5-byte transfer, no pause
    pkt_len_m1 = 4; pkt_loop_m1 = 0; hs_cnt = 0;
    pulse(go);
    wait_state(2'd0);
    chk("R1 5 bytes", hs_cnt, 5);
    chk("R4 finish flag", status[0], 1'b1);
    chk("R8 irq on finish", irq, 1'b1);
    pulse(resume); step(2);
    chk("R3 resume in idle ignored", status[3:2], 2'd0);
    pulse(stat_rd); step(1);
    chk("R9 flags cleared", status[1:0], 2'b00);
    // 3x3 bytes with pause, stalling engine, stray go
    pkt_len_m1 = 2; pkt_loop_m1 = 2; pause_en = 1; ser_toggle = 1; hs_cnt = 0;
    pulse(go); step(3);
    pulse(go);
    wait_state(2'd2);
    chk("R1 R2 nine bytes", hs_cnt, 9);
    chk("R4 cs held in pause", cs_active, 1'b1);
    chk("R4 pause flag", status[1], 1'b1);
    pulse(go); step(2);
    chk("R2 go while paused ignored", status[3:2], 2'd2);
    pause_en = 0; pkt_len_m1 = 6; pkt_loop_m1 = 0; hs_cnt = 0;
    pulse(resume);
    pkt_len_m1 = 0;
    wait_state(2'd0);
    chk("R3 R1 resume transfer latched", hs_cnt, 7);
    pulse(stat_rd);
    // receive back-pressure
    ser_toggle = 0; rx_drain = 0; step(30);
    pkt_len_m1 = 39; hs_cnt = 0;
    pulse(go); step(80);
    chk("R10 stall when rx full", hs_cnt, 32);
    chk("R10 still busy", status[3:2], 2'd1);
    rx_drain = 1;
    wait_state(2'd0);
    chk("R1 forty bytes", hs_cnt, 40);
    // software reset mid transfer
    pkt_len_m1 = 99; pkt_loop_m1 = 1; rx_drain = 0;
    pulse(go); step(10);
    soft_rst = 1; step(2);
    chk("R5 idle", status, 4'h0);
    chk("R5 tx_wready low", tx_wready, 1'b0);
    chk("R5 rx_rvalid low", rx_rvalid, 1'b0);
    soft_rst = 0; rx_drain = 1; step(12);
    pkt_len_m1 = 2; pkt_loop_m1 = 0; hs_cnt = 0;
    pulse(go);
    wait_state(2'd0);
    chk("R5 R7 after reset", hs_cnt, 3);
    step(10);
    finish_run();
  end
endmodule